// File: doc/BRIEF.md
# Transmit packet queue manager

This block keeps track of the transmit buffers of a packet-buffer Ethernet controller by small packet numbers. The host issues single-cycle commands: allocate a buffer, enqueue the number held in the packet number register, release that number, and acknowledge a finished packet. Allocation hands out the lowest number not in use and reports it through an allocation-done bit and a result value. The done bit can be polled, or unmasked to form an interrupt.

Enqueued numbers wait in order in a transmit FIFO. While transmit is enabled, the head number is offered to the MAC over a request/done handshake. Each finished number moves into a completion FIFO, a status pulse is issued for it, and the transmit interrupt stays high while that FIFO holds entries.

A failed transmission clears transmit-enable, so nothing more is sent. The failing number then sits at the head of the completion FIFO, where the host reads it. Reading the head does not remove it. A separate acknowledge command pops it.

Top module: `txq_mgr`

## Requirements
- R1: An allocate command (cmd_i = 1) grants the lowest free packet number at the same clock edge. After that edge alloc_done_o is 1 and alloc_pkt_o holds the number, which becomes in use.
- R2: If no number is free, the request stays pending with alloc_done_o at 0. It is granted at the edge after a release (cmd_i = 3) frees a number. alloc_done_o stays set until the next allocate command.
- R3: alloc_irq_o is 1 exactly when alloc_done_o and alloc_mask_i are both 1.
- R4: An enqueue command (cmd_i = 2) pushes the packet number register into the transmit FIFO. The register is loaded by pnr_we_i at an earlier edge, and the push clears txq_empty_o.
- R5: mac_req_o is 1 only while transmit is enabled and the transmit FIFO is not empty. mac_pkt_o presents the queued numbers in enqueue order.
- R6: When mac_done_i is 1 during a request, stat_we_o pulses with stat_pkt_o equal to the head number and stat_ok_o equal to mac_ok_i. At that edge the number leaves the transmit FIFO and enters the completion FIFO.
- R7: tx_irq_o is 1 while the completion FIFO holds entries. cmpl_head_o shows the oldest entry without removing it. An acknowledge command (cmd_i = 4) pops one entry.
- R8: A completion with mac_ok_i = 0 clears txen_o at that edge. It halts all further requests, and the failing number appears at cmpl_head_o.
- R9: A release command returns the number in the packet number register to the free pool, so that a later allocation can grant it again.
- R10: The transmit FIFO holds 32 entries. An enqueue while it is full is dropped and sets enq_err_o, which stays set until reset.
- R11: After reset no number is in use and both FIFOs are empty. alloc_done_o, txen_o, tx_irq_o, enq_err_o and mac_req_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 3 | Command: 0 none, 1 allocate, 2 enqueue, 3 release, 4 acknowledge |
| pnr_we_i | input | 1 | Load the packet number register |
| pnr_i | input | 5 | Value for the packet number register |
| txen_we_i | input | 1 | Write transmit-enable |
| txen_i | input | 1 | Transmit-enable value to write |
| alloc_mask_i | input | 1 | Unmask the allocation-done interrupt |
| mac_done_i | input | 1 | MAC finished the requested packet |
| mac_ok_i | input | 1 | Outcome qualifying mac_done_i (1 = success) |
| alloc_done_o | output | 1 | Allocation-done bit |
| alloc_pkt_o | output | 5 | Last granted packet number |
| alloc_irq_o | output | 1 | Masked allocation interrupt |
| txen_o | output | 1 | Transmit-enable state |
| txq_empty_o | output | 1 | Transmit FIFO empty |
| cmpl_empty_o | output | 1 | Completion FIFO empty |
| cmpl_head_o | output | 5 | Oldest completion entry |
| tx_irq_o | output | 1 | Transmit interrupt |
| enq_err_o | output | 1 | Sticky enqueue-overflow flag |
| mac_req_o | output | 1 | Packet offered to the MAC |
| mac_pkt_o | output | 5 | Number of the offered packet |
| stat_we_o | output | 1 | Status word write strobe |
| stat_pkt_o | output | 5 | Packet the status belongs to |
| stat_ok_o | output | 1 | Status outcome |

## Verification
A corrupted allocation vector shows on the first grant after the fault: a duplicate or skipped number at alloc_pkt_o, or a missing done bit while numbers are free. A pointer or count error in either FIFO shows within one handshake as an out-of-order mac_pkt_o or cmpl_head_o, an early or late change of an empty flag, or a transmit interrupt that fails to drop. A lost failure path shows in the very next cycle as mac_req_o remaining high after a failed completion.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_ALLOC = 3'd1,
    CMD_ENQ   = 3'd2,
    CMD_REL   = 3'd3,
    CMD_ACK   = 3'd4
  } txq_cmd_e;
endpackage

// File: rtl/txq_free_pool.sv
module txq_free_pool #(
  parameter int unsigned NUM_PKTS = 32,
  parameter int unsigned PKT_W    = $clog2(NUM_PKTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             rel_i,
  input  logic [PKT_W-1:0] rel_num_i,
  output logic             grant_o,
  output logic [PKT_W-1:0] grant_num_o
);
  logic [NUM_PKTS-1:0] used_q;
  logic                any_free;

  // lowest free wins: scan downward so the last hit is the smallest index
  always_comb begin
    any_free    = 1'b0;
    grant_num_o = '0;
    for (int i = NUM_PKTS - 1; i >= 0; i--) begin
      if (!used_q[i]) begin
        any_free    = 1'b1;
        grant_num_o = PKT_W'(i);
      end
    end
  end

  assign grant_o = req_i & any_free;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q <= '0;
    end else begin
      if (rel_i)   used_q[rel_num_i]   <= 1'b0;
      if (grant_o) used_q[grant_num_o] <= 1'b1;
    end
  end

  p_grant_free_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> !used_q[grant_num_o]);
  p_grant_marks_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> used_q[$past(grant_num_o)]);
endmodule

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + 1'b1;
      if (pop_i)  rd_q <= rd_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_no_underflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_push_fills_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> !empty_o);
endmodule

// File: rtl/txq_mgr.sv
module txq_mgr
  import txq_pkg::*;
#(
  parameter int unsigned NUM_PKTS   = 32,
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned PKT_W      = $clog2(NUM_PKTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       cmd_i,
  input  logic             pnr_we_i,
  input  logic [PKT_W-1:0] pnr_i,
  input  logic             txen_we_i,
  input  logic             txen_i,
  input  logic             alloc_mask_i,
  input  logic             mac_done_i,
  input  logic             mac_ok_i,
  output logic             alloc_done_o,
  output logic [PKT_W-1:0] alloc_pkt_o,
  output logic             alloc_irq_o,
  output logic             txen_o,
  output logic             txq_empty_o,
  output logic             cmpl_empty_o,
  output logic [PKT_W-1:0] cmpl_head_o,
  output logic             tx_irq_o,
  output logic             enq_err_o,
  output logic             mac_req_o,
  output logic [PKT_W-1:0] mac_pkt_o,
  output logic             stat_we_o,
  output logic [PKT_W-1:0] stat_pkt_o,
  output logic             stat_ok_o
);
  txq_cmd_e cmd;
  assign cmd = txq_cmd_e'(cmd_i);

  logic [PKT_W-1:0] pnr_q, res_q, grant_num, txq_head;
  logic pend_q, done_q, txen_q, err_q;
  logic alloc_req, grant, enq_ok, ack_ok, xfer, fail;
  logic txq_full, cmpl_full;

  assign alloc_req = pend_q | (cmd == CMD_ALLOC);
  assign enq_ok    = (cmd == CMD_ENQ) & ~txq_full;
  assign ack_ok    = (cmd == CMD_ACK) & ~cmpl_empty_o;
  assign mac_req_o = txen_q & ~txq_empty_o & ~cmpl_full;
  assign xfer      = mac_req_o & mac_done_i;
  assign fail      = xfer & ~mac_ok_i;

  txq_free_pool #(.NUM_PKTS(NUM_PKTS), .PKT_W(PKT_W)) u_pool (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (alloc_req),
    .rel_i       (cmd == CMD_REL),
    .rel_num_i   (pnr_q),
    .grant_o     (grant),
    .grant_num_o (grant_num)
  );

  txq_fifo #(.DEPTH(FIFO_DEPTH), .W(PKT_W)) u_txq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (enq_ok),
    .data_i  (pnr_q),
    .pop_i   (xfer),
    .head_o  (txq_head),
    .empty_o (txq_empty_o),
    .full_o  (txq_full)
  );

  txq_fifo #(.DEPTH(FIFO_DEPTH), .W(PKT_W)) u_cmpl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (xfer),
    .data_i  (txq_head),
    .pop_i   (ack_ok),
    .head_o  (cmpl_head_o),
    .empty_o (cmpl_empty_o),
    .full_o  (cmpl_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pnr_q  <= '0;
      res_q  <= '0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
      txen_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (pnr_we_i) pnr_q <= pnr_i;
      if (grant) begin
        res_q  <= grant_num;
        done_q <= 1'b1;
        pend_q <= 1'b0;
      end else if (cmd == CMD_ALLOC) begin
        done_q <= 1'b0;
        pend_q <= 1'b1;
      end
      // a failure overrides a host write in the same cycle
      if (fail)           txen_q <= 1'b0;
      else if (txen_we_i) txen_q <= txen_i;
      if ((cmd == CMD_ENQ) && txq_full) err_q <= 1'b1;
    end
  end

  assign alloc_done_o = done_q;
  assign alloc_pkt_o  = res_q;
  assign alloc_irq_o  = done_q & alloc_mask_i;
  assign txen_o       = txen_q;
  assign tx_irq_o     = ~cmpl_empty_o;
  assign enq_err_o    = err_q;
  assign mac_pkt_o    = txq_head;
  assign stat_we_o    = xfer;
  assign stat_pkt_o   = txq_head;
  assign stat_ok_o    = mac_ok_i;

  p_fail_halt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail |=> (!txen_o && !mac_req_o && tx_irq_o));
  p_req_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_req_o |-> (txen_o && !txq_empty_o));
  p_done_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && cmd != CMD_ALLOC) |=> done_q);
  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  p_cmpl_fill_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer |=> tx_irq_o);
endmodule

// File: tb/sim_txq_mgr.sv
module sim_txq_mgr;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] cmd_i = 3'd0;
  logic       pnr_we_i = 1'b0;
  logic [4:0] pnr_i = '0;
  logic       txen_we_i = 1'b0, txen_i = 1'b0, alloc_mask_i = 1'b0;
  logic       mac_done_i = 1'b0, mac_ok_i = 1'b0;
  logic       alloc_done_o, alloc_irq_o, txen_o, txq_empty_o, cmpl_empty_o;
  logic       tx_irq_o, enq_err_o, mac_req_o, stat_we_o, stat_ok_o;
  logic [4:0] alloc_pkt_o, cmpl_head_o, mac_pkt_o, stat_pkt_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  txq_mgr u0 (.*);

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic do_cmd(int op);
    cmd_i = 3'(op); step(); cmd_i = 3'd0;
  endtask

  task automatic set_pnr(int v);
    pnr_we_i = 1'b1; pnr_i = 5'(v); step(); pnr_we_i = 1'b0;
  endtask

  task automatic set_txen(bit v);
    txen_we_i = 1'b1; txen_i = v; step(); txen_we_i = 1'b0;
  endtask

  task automatic mac_finish(bit ok);
    mac_done_i = 1'b1; mac_ok_i = ok; step(); mac_done_i = 1'b0; mac_ok_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 alloc_done", alloc_done_o, 0);
    chk("R11 txen", txen_o, 0);
    chk("R11 tx_irq", tx_irq_o, 0);
    chk("R11 enq_err", enq_err_o, 0);
    chk("R11 mac_req", mac_req_o, 0);
    chk("R11 txq_empty", txq_empty_o, 1);
    chk("R11 cmpl_empty", cmpl_empty_o, 1);
  endtask

  task automatic t_alloc();
    for (int i = 0; i < 3; i++) begin
      do_cmd(1);
      chk("R1 done", alloc_done_o, 1);
      chk("R1 lowest number", alloc_pkt_o, i);
    end
    chk("R3 masked irq", alloc_irq_o, 0);
    alloc_mask_i = 1'b1; #1;
    chk("R3 unmasked irq", alloc_irq_o, 1);
    alloc_mask_i = 1'b0; #1;
  endtask

  task automatic t_exhaust();
    for (int i = 3; i < 32; i++) begin
      do_cmd(1);
      chk("R1 sequential grant", alloc_pkt_o, i);
    end
    do_cmd(1);
    chk("R2 none free", alloc_done_o, 0);
    step(); step(); step();
    chk("R2 still pending", alloc_done_o, 0);
    set_pnr(5);
    do_cmd(3);
    chk("R2 grant after release edge", alloc_done_o, 0);
    step();
    chk("R9 released number granted", alloc_done_o, 1);
    chk("R9 released number value", alloc_pkt_o, 5);
    step();
    chk("R2 done holds", alloc_done_o, 1);
  endtask

  task automatic t_tx();
    set_pnr(7); do_cmd(2);
    set_pnr(3); do_cmd(2);
    chk("R4 txq not empty", txq_empty_o, 0);
    chk("R5 no req while disabled", mac_req_o, 0);
    set_txen(1'b1);
    chk("R5 req enabled", mac_req_o, 1);
    chk("R5 first in order", mac_pkt_o, 7);
    mac_done_i = 1'b1; mac_ok_i = 1'b1; #1;
    chk("R6 stat strobe", stat_we_o, 1);
    chk("R6 stat pkt", stat_pkt_o, 7);
    chk("R6 stat ok", stat_ok_o, 1);
    step(); mac_done_i = 1'b0; mac_ok_i = 1'b0;
    chk("R6 moved to completion", cmpl_head_o, 7);
    chk("R7 irq on", tx_irq_o, 1);
    chk("R5 second in order", mac_pkt_o, 3);
    mac_finish(1'b1);
    step();
    chk("R7 head read no pop", cmpl_head_o, 7);
    chk("R5 queue drained", mac_req_o, 0);
    do_cmd(4);
    chk("R7 ack pops", cmpl_head_o, 3);
    chk("R7 irq held", tx_irq_o, 1);
    do_cmd(4);
    chk("R7 irq drops", tx_irq_o, 0);
    chk("R7 cmpl empty", cmpl_empty_o, 1);
  endtask

  task automatic t_fail();
    set_pnr(9); do_cmd(2);
    set_pnr(10); do_cmd(2);
    chk("R5 req head 9", mac_pkt_o, 9);
    mac_done_i = 1'b1; mac_ok_i = 1'b0; #1;
    chk("R8 stat fail", stat_ok_o, 0);
    chk("R8 stat pkt", stat_pkt_o, 9);
    step(); mac_done_i = 1'b0;
    chk("R8 txen cleared", txen_o, 0);
    chk("R8 req halted", mac_req_o, 0);
    chk("R8 failing number", cmpl_head_o, 9);
    chk("R8 irq", tx_irq_o, 1);
    chk("R8 rest kept queued", txq_empty_o, 0);
    step(); step(); step();
    chk("R8 stays halted", mac_req_o, 0);
    do_cmd(4);
    set_txen(1'b1);
    chk("R5 resumes with 10", mac_pkt_o, 10);
    mac_finish(1'b1);
    chk("R6 10 completed", cmpl_head_o, 10);
    do_cmd(4);
    chk("R7 empty after ack", cmpl_empty_o, 1);
  endtask

  task automatic t_full();
    set_txen(1'b0);
    for (int i = 0; i < 32; i++) begin
      set_pnr(i); do_cmd(2);
    end
    chk("R10 no error at capacity", enq_err_o, 0);
    set_pnr(20); do_cmd(2);
    chk("R10 overflow flagged", enq_err_o, 1);
    set_txen(1'b1);
    for (int i = 0; i < 32; i++) begin
      chk("R5 drain order", mac_pkt_o, i);
      mac_finish(1'b1);
    end
    chk("R10 extra enqueue dropped", mac_req_o, 0);
    chk("R10 txq empty", txq_empty_o, 1);
    chk("R7 oldest completion", cmpl_head_o, 0);
    for (int i = 0; i < 32; i++) do_cmd(4);
    chk("R7 all acked", cmpl_empty_o, 1);
    chk("R10 error sticky", enq_err_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    step();
    t_reset();
    t_alloc();
    t_exhaust();
    t_tx();
    t_fail();
    t_full();
    report();
  end
endmodule